// File: doc/BRIEF.md
# Coherent Byte-Wide Reader for Wide Result Registers

This block sits between an 8-bit bus master and a bank of four 16-bit result registers that a converter updates on its own schedule. Without help, a master that fetches a result as two single-byte accesses can see the converter overwrite the value between the two reads, so it gets one byte of an old sample and one byte of a new one. The block prevents that with one shared shadow byte. Reading the upper half of any register also captures that register's lower half into the shadow byte. Every lower-half address then returns the shadow byte, not the live register.

The master's software reads the upper byte first and the lower byte next. The two bytes then always come from the same sample, even if the converter writes the register in between. A lower-byte read with no upper read before it is not corrected. It returns whatever the shadow byte last captured, which can be an old value or a byte from a different register. The converter side has a single write port. It can replace any register in any cycle, and the write takes effect at the clock edge.

Top module: `coherent_result_port`

## Requirements
- R1: Register k (k = 0..3, for results A..D) has its upper byte at byte address 2k and its lower byte at byte address 2k+1. Address bit 0 selects the half: 0 means upper, 1 means lower.
- R2: While `bus_rd` is high with an even address, `bus_rdata` shows the live upper byte of the addressed register in that same cycle.
- R3: At the clock edge that ends an upper-byte read, the shadow byte captures the live lower byte of the addressed register.
- R4: While `bus_rd` is high with an odd address, `bus_rdata` shows the shadow byte, whichever register the address names.
- R5: A lower-byte read with no upper-byte read before it returns the shadow byte as it stands. That value may be stale or may belong to another register. A lower-byte read never changes the shadow byte.
- R6: A converter write to a register after its upper byte has been read does not change what the next lower-byte read returns.
- R7: If a converter write and an upper-byte read hit the same register in the same cycle, the read returns the upper byte from before the write. The shadow byte captures the lower byte from before the write.
- R8: A converter write (`cv_we`) stores `cv_data` into register `cv_sel` at the clock edge. The next upper-byte read of that register returns the new value.
- R9: `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R10: Bus writes (`bus_wr` with `bus_wdata`) change neither the result registers nor the shadow byte.
- R11: After reset, every result register holds 0x0000 and the shadow byte holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Write strobe; ignored |
| bus_addr | input | 3 | Byte address |
| bus_wdata | input | 8 | Write data; ignored |
| bus_rdata | output | 8 | Read data |
| cv_we | input | 1 | Converter write enable |
| cv_sel | input | 2 | Register selected by the converter |
| cv_data | input | 16 | New result value |

## Verification
The bench builds the block with its default parameters: four registers, 16-bit results and an 8-bit bus, which gives a 3-bit byte address. With these values every byte address is decoded. The ordered case, the upper-only case and the stale lower-read case are all reachable, and so are the two cross-register cases: a read of A's upper byte followed by a read of B's lower address, and a converter write that lands between the two halves of a read. A cycle-accurate model in the bench predicts `bus_rdata` in every cycle, including idle cycles and cycles with only bus writes.

// File: rtl/crr_pkg.sv
package crr_pkg;

   typedef enum logic {
      HALF_UPPER = 1'b0,
      HALF_LOWER = 1'b1
   } half_e;

endpackage

// File: rtl/crr_result_bank.sv
module crr_result_bank #(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 16,
   localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_sel,
   input  logic [DATA_W-1:0]                wr_val,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[g] <= '0;
         end else if (wr_en && (wr_sel == IDX_W'(g))) begin
            regs_q[g] <= wr_val;
         end
      end
   end

   // R8: a converter write appears in the selected register one edge later
   assert_cv_write_lands_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> regs_q[$past(wr_sel)] == $past(wr_val));

endmodule

// File: rtl/crr_shadow_byte.sv
module crr_shadow_byte #(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [BUS_W-1:0] cap_val,
   output logic [BUS_W-1:0] shadow_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (cap_en) begin
         shadow_q <= cap_val;
      end
   end

endmodule

// File: rtl/crr_read_path.sv
module crr_read_path
   import crr_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 16,
   parameter int BUS_W    = 8,
   localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int ADDR_W  = IDX_W + 1
) (
   input  logic                            rd,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [BUS_W-1:0]                shadow,
   output logic [BUS_W-1:0]                rdata,
   output logic                            cap_en,
   output logic [BUS_W-1:0]                cap_val
);

   half_e            half;
   logic [IDX_W-1:0] idx;
   logic [DATA_W-1:0] word;

   always_comb begin
      half    = half_e'(addr[0]);
      idx     = addr[ADDR_W-1:1];
      word    = regs[idx];
      cap_en  = rd && (half == HALF_UPPER);
      cap_val = word[BUS_W-1:0];
      if (!rd) begin
         rdata = '0;
      end else if (half == HALF_UPPER) begin
         rdata = word[DATA_W-1:BUS_W];
      end else begin
         rdata = shadow;
      end
   end

endmodule

// File: rtl/coherent_result_port.sv
module coherent_result_port
   import crr_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 16,
   parameter int BUS_W    = 8,
   localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int ADDR_W  = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              cv_we,
   input  logic [IDX_W-1:0]  cv_sel,
   input  logic [DATA_W-1:0] cv_data
);

   if (DATA_W != 2 * BUS_W) begin : g_bad_width
      $error("coherent_result_port: DATA_W must be twice BUS_W");
   end
   if (NUM_REGS < 2 || NUM_REGS != (1 << IDX_W)) begin : g_bad_count
      $error("coherent_result_port: NUM_REGS must be a power of two, at least 2");
   end

   // bus writes have no target in this block
   logic unused_bus_write;
   assign unused_bus_write = bus_wr ^ (^bus_wdata);

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic [BUS_W-1:0]                shadow_q;
   logic                            cap_en;
   logic [BUS_W-1:0]                cap_val;

   crr_result_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cv_we),
      .wr_sel (cv_sel),
      .wr_val (cv_data),
      .regs_q (regs_q)
   );

   crr_shadow_byte #(.BUS_W(BUS_W)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_val  (cap_val),
      .shadow_q (shadow_q)
   );

   crr_read_path #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_read (
      .rd      (bus_rd),
      .addr    (bus_addr),
      .regs    (regs_q),
      .shadow  (shadow_q),
      .rdata   (bus_rdata),
      .cap_en  (cap_en),
      .cap_val (cap_val)
   );

   // R3: an upper read loads the addressed register's lower byte as it stood before the edge
   assert_upper_loads_shadow_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_addr[0])
      |=> shadow_q == $past(regs_q[bus_addr[ADDR_W-1:1]][BUS_W-1:0]));

   // R5, R10: without an upper read, the shadow byte holds its value
   assert_shadow_holds_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && !bus_addr[0]) |=> $stable(shadow_q));

   // R4: a lower-half read presents the shadow byte
   assert_lower_from_shadow_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[0]) |-> bus_rdata == shadow_q);

   // R2: an upper-half read presents the live upper byte
   assert_upper_live_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_addr[0]) |-> bus_rdata == regs_q[bus_addr[ADDR_W-1:1]][DATA_W-1:BUS_W]);

   // R9: the read bus is quiet without a strobe
   assert_idle_zero_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);

endmodule

// File: tb/coherent_result_port_tb.sv
module coherent_result_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        cv_we = 1'b0;
   logic [1:0]  cv_sel = '0;
   logic [15:0] cv_data = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int m_regs [4];
   int m_shadow;

   always #5 clk = ~clk;

   coherent_result_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cv_we(cv_we), .cv_sel(cv_sel), .cv_data(cv_data)
   );

   // One bus cycle: drive, compare against the model, then advance the model at the edge.
   task automatic step(input bit rd, input bit wr, input int addr, input int wdata,
                       input bit we, input int sel, input int data, input string tag);
      int exp_v;
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = 3'(addr); bus_wdata = 8'(wdata);
      cv_we = we; cv_sel = 2'(sel); cv_data = 16'(data);
      #2;
      if (!rd) exp_v = 0;
      else if (addr % 2 == 1) exp_v = m_shadow;
      else exp_v = (m_regs[addr / 2] >> 8) & 8'hFF;
      total++;
      if (int'(bus_rdata) != exp_v) begin
         bad++;
         $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, addr, bus_rdata, exp_v);
      end
      @(posedge clk);
      if (rd && (addr % 2 == 0)) m_shadow = m_regs[addr / 2] & 8'hFF;
      if (we) m_regs[sel] = data & 16'hFFFF;
   endtask

   task automatic rd_only(input int addr, input string tag);
      step(1'b1, 1'b0, addr, 0, 1'b0, 0, 0, tag);
   endtask

   task automatic cv_only(input int sel, input int data, input string tag);
      step(1'b0, 1'b0, 0, 0, 1'b1, sel, data, tag);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      foreach (m_regs[i]) m_regs[i] = 0;
      m_shadow = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R11: reset values, every address; R1 decode of all offsets
      for (int a = 0; a < 8; a++) rd_only(a, "R11");
      // R9 idle bus
      step(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, "R9");

      // R8 load all registers, R1 offsets
      cv_only(0, 16'hAA40, "R8");
      cv_only(1, 16'h1234, "R8");
      cv_only(2, 16'hBEEF, "R8");
      cv_only(3, 16'h5A0F, "R8");

      // R2 R3 R4 ordered reads of each register
      for (int k = 0; k < 4; k++) begin
         rd_only(2 * k, "R2");
         rd_only(2 * k + 1, "R4");
      end

      // R5: upper-only read of C, then lower of D returns C's low byte
      rd_only(4, "R3");
      step(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, "R9");
      rd_only(7, "R5");
      rd_only(7, "R5");

      // cross register: upper of A then lower address of B returns A's lower byte
      rd_only(0, "R2");
      rd_only(3, "R4");

      // R6: converter write between halves
      rd_only(2, "R2");
      cv_only(1, 16'h9988, "R6");
      rd_only(3, "R6");
      rd_only(2, "R8");
      rd_only(3, "R4");

      // R7: same-cycle write and upper read of D
      step(1'b1, 1'b0, 6, 0, 1'b1, 3, 16'hC3E1, "R7");
      rd_only(7, "R7");
      rd_only(6, "R8");
      rd_only(7, "R8");

      // R10: bus writes with idle and with lower reads
      step(1'b0, 1'b1, 0, 8'hFF, 1'b0, 0, 0, "R10");
      step(1'b0, 1'b1, 1, 8'h77, 1'b0, 0, 0, "R10");
      step(1'b1, 1'b1, 5, 8'h66, 1'b0, 0, 0, "R10");
      for (int a = 0; a < 8; a += 2) rd_only(a, "R10");
      rd_only(1, "R10");

      // write while idle, then lower-only read still stale (R5)
      cv_only(2, 16'h0102, "R5");
      rd_only(5, "R5");
      rd_only(4, "R8");
      rd_only(5, "R4");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule